// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a target on a two-wire serial bus, the open-drain clock and data pair used to set up control registers. It gives an external controller byte-wide read and write access to a 256-entry configuration register file. Both bus lines are sampled by the system clock through a two-flop synchronizer, and bus events are taken from the synchronized edges. The data line is driven only through an open-drain enable. When the enable is high the pad pulls the line low.

After a bus start the first byte holds a 7-bit target address and a direction bit. A write then carries one register index followed by any number of data bytes. A read returns bytes from an internal pointer that survives from one transaction to the next. This supports current-position reads, indexed reads made with a repeated start, and sequential reads. Other logic on the chip sees the register contents through a combinational lookup port. There is no flow-controlled stream at the block's edge, so every pin is a plain control or data pin.

Top module: `twi_regfile_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is low and register i holds the default value i XOR 8'h5A.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. The first byte after any start is sent MSB first: seven address bits, then the direction bit (0 = write, 1 = read). With address 7'h69 the block pulls the data line low for the whole ninth clock.
- R3: `sda_oe` changes only while `scl_in` is low. Read bytes are presented MSB first, and each bit is set up after a falling edge of the clock line.
- R4: If the address does not match, `sda_oe` stays low until the next start or stop. The bytes that follow do not change any register or the pointer, and a read attempt returns 8'hFF on the bus.
- R5: In a write, the byte after the address byte sets the pointer, and the next byte is stored at that index. Each of these bytes is acknowledged on its ninth clock.
- R6: Each further data byte before the stop is stored at the next index, and the pointer then holds one more than the last index written.
- R7: An indexed read is a write of the index, then a repeated start, then the address with direction 1. It returns the register at that index, and no register is written.
- R8: During a read, a controller acknowledge (data line low on the ninth clock) makes the block send the register at the next index. A controller non-acknowledge makes it release the line for the rest of the transaction.
- R9: A read with no index phase returns the register at the pointer, which is one more than the last index written or read, even in an earlier transaction.
- R10: The pointer steps from 8'hFF to 8'h00 in both burst writes and sequential reads.
- R11: `cfg_data` always shows the current contents of register `cfg_addr`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND result) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| cfg_addr | input | 8 | Register index looked up for on-chip logic |
| cfg_data | output | 8 | Contents of register `cfg_addr` |

## Verification
The assertions assume a well-behaved controller. It changes the data line only while the clock line is low, except to make starts and stops. It never issues a stop or start while the block is pulling the data line low. Each clock half-period is several system clocks long, so the block's reaction to a falling clock edge ends before the next rising edge. The bench drives every bus bit as four phases of four system clocks each: clock low, data change, clock high, then sample. It issues starts and stops only when the data line has been released, so the stimulus stays within these assumptions.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // bus free or not addressed yet
    ST_RX,    // shifting in a byte from the controller
    ST_ACK,   // pulling data low during the ninth clock
    ST_TX,    // shifting out a read byte
    ST_MACK,  // sampling the controller's acknowledge
    ST_SKIP   // silent until next start or stop
  } twi_state_e;

  typedef enum logic [1:0] {
    RX_DEV,   // target address plus direction
    RX_REG,   // register index
    RX_DATA   // write payload
  } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter logic [DW-1:0] DEF_XOR = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i) ^ DEF_XOR;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         AW          = 8,
  parameter logic [7:0] DEF_XOR     = 8'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [AW-1:0] cfg_addr,
  output logic [7:0]    cfg_data
);
  localparam int DW     = 8;
  localparam int CNT_W  = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
  logic [1:0] lvl, rise, fall;

  twi_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );
  assign {scl_s, sda_s}       = lvl;
  assign {scl_rise, sda_rise} = rise;
  assign {scl_fall, sda_fall} = fall;

  logic start_ev, stop_ev;
  assign start_ev = sda_fall & scl_s;
  assign stop_ev  = sda_rise & scl_s;

  twi_state_e        state;
  rx_kind_e          kind;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     shreg, txsh, rd_byte;
  logic [AW-1:0]     ptr;
  logic              rw, mack, oe_q;
  logic              wr_en, rd_load, quiet;

  assign quiet   = !start_ev && !stop_ev;
  assign wr_en   = quiet && state == ST_RX && kind == RX_DATA && scl_fall && cnt == FULL;
  assign rd_load = quiet && scl_fall &&
                   ((state == ST_ACK && kind == RX_DEV && rw) || (state == ST_MACK && mack));

  twi_regfile #(.AW(AW), .DW(DW), .DEF_XOR(DEF_XOR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_addr_a(ptr), .rd_data_a(rd_byte),
    .rd_addr_b(cfg_addr), .rd_data_b(cfg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= RX_DEV; cnt <= '0; shreg <= '0; txsh <= '0;
      ptr <= '0; rw <= 1'b0; mack <= 1'b0; oe_q <= 1'b0;
    end else if (start_ev) begin
      state <= ST_RX; kind <= RX_DEV; cnt <= '0; oe_q <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; oe_q <= 1'b0;
    end else if (rd_load) begin
      txsh  <= {rd_byte[DW-2:0], 1'b0};
      oe_q  <= ~rd_byte[DW-1];
      ptr   <= ptr + 1'b1;
      cnt   <= '0;
      state <= ST_TX;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt <= '0;
            case (kind)
              RX_DEV: begin
                if (shreg[DW-1:1] == DEV_ADDR) begin
                  rw <= shreg[0]; oe_q <= 1'b1; state <= ST_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end
              RX_REG: begin
                ptr <= shreg[AW-1:0]; oe_q <= 1'b1; state <= ST_ACK;
              end
              default: begin
                ptr <= ptr + 1'b1; oe_q <= 1'b1; state <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_RX;
            kind  <= (kind == RX_DEV) ? RX_REG : RX_DATA;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              oe_q <= 1'b0; state <= ST_MACK;
            end else begin
              oe_q <= ~txsh[DW-1];
              txsh <= {txsh[DW-2:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) state <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          in_skip,
  input logic          wr_en,
  input logic          rd_load,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr
);
  // R3: the pad enable moves only in the low half of the bus clock
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R4: an unaddressed transaction leaves the line released
  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !sda_oe);

  // R6 and R10: a stored byte moves the pointer one past its index, wrapping
  p_wr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(wr_addr) + 1'b1);

  // R8 and R10: each byte loaded for reading advances the pointer by one
  p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ptr == $past(ptr) + 1'b1);
endmodule

bind twi_regfile_slave twi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .in_skip(state == twi_pkg::ST_SKIP), .wr_en(wr_en), .rd_load(rd_load),
  .wr_addr(ptr), .ptr(ptr)
);

// File: tb/twi_regfile_slave_bench.sv
module twi_regfile_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam logic [6:0] DEV   = 7'h69;
  localparam logic [7:0] DEFX  = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  logic [7:0] model [256];
  int         mptr = 0;
  logic [7:0] wq [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  twi_regfile_slave u_twi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    scl = 1'b0; wait_q();
    m_sda = b;  wait_q();
    scl = 1'b1; wait_q();
    seen = sda_line; wait_q();
  endtask

  task automatic cond_start();
    scl = 1'b0; wait_q();
    m_sda = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
  endtask

  task automatic cond_stop();
    scl = 1'b0; wait_q();
    m_sda = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(!give_ack, s);
  endtask

  // write the bytes in wq after an index phase; hit says whether the address matches
  task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input bit hit, input string tag);
    logic a;
    cmp_en = 1'b0;
    cond_start();
    put_byte({dev, 1'b0}, a);
    chk(a == hit, {tag, " R2 address ack"}, a, hit);
    put_byte(ra, a);
    chk(a == hit, {tag, " R5 index ack"}, a, hit);
    if (hit) mptr = ra;
    foreach (wq[k]) begin
      put_byte(wq[k], a);
      chk(a == hit, {tag, " R6 data ack"}, a, hit);
      if (hit) begin
        model[mptr] = wq[k];
        mptr = (mptr + 1) % 256;
      end
    end
    cond_stop();
    wait_q();
    cmp_en = 1'b1;
  endtask

  // read n bytes, optionally after an index phase and a repeated start
  task automatic do_read(input logic [6:0] dev, input bit use_idx, input logic [7:0] ra,
                         input int n, input bit hit, input string tag);
    logic a;
    logic [7:0] b, e;
    cond_start();
    if (use_idx) begin
      put_byte({dev, 1'b0}, a);
      chk(a == hit, {tag, " R7 index address ack"}, a, hit);
      put_byte(ra, a);
      chk(a == hit, {tag, " R7 index ack"}, a, hit);
      if (hit) mptr = ra;
      cond_start();
    end
    put_byte({dev, 1'b1}, a);
    chk(a == hit, {tag, " R2 read address ack"}, a, hit);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      e = hit ? model[mptr] : 8'hFF;
      chk(b == e, {tag, " R8 read byte"}, b, e);
      if (hit) mptr = (mptr + 1) % 256;
    end
    cond_stop();
    wait_q();
  endtask

  // reference comparison on every clock: the lookup port against the model (R1, R11)
  initial begin
    forever begin
      @(negedge clk);
      if (cmp_en) chk(cfg_data == model[cfg_addr], "R11 lookup vs model", cfg_data, model[cfg_addr]);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cfg_addr <= cfg_addr + 8'd1;
    end
  end

  // R3: the enable may only move while the bus clock is low
  initial begin
    logic prev_oe;
    prev_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe != prev_oe) chk(scl == 1'b0, "R3 enable moved with clock high", scl, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ DEFX;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 enable in reset", sda_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 enable after reset", sda_oe, 0);
    cmp_en = 1'b1;
    repeat (300) @(negedge clk);   // full sweep of defaults

    // R5: single write
    wq = '{8'h3C};
    do_write(DEV, 8'h10, 1'b1, "single");
    // R9: current read returns index 0x11
    do_read(DEV, 1'b0, 8'h00, 1, 1'b1, "R9 current after write");
    // R6 R10: burst across the top of the index space
    wq = '{8'hA1, 8'hB2, 8'hC3};
    do_write(DEV, 8'hFE, 1'b1, "R10 burst wrap");
    // R9: pointer now 0x01 after wrap
    do_read(DEV, 1'b0, 8'h00, 1, 1'b1, "R9 current after wrap");
    // R7 R8 R10: indexed sequential read through 0xFF -> 0x00 -> 0x01
    do_read(DEV, 1'b1, 8'hFF, 3, 1'b1, "R7 R10 indexed sequential");
    // R4: wrong address, write must not land
    wq = '{8'h99, 8'h77};
    do_write(7'h68, 8'h20, 1'b0, "R4 mismatch write");
    repeat (300) @(negedge clk);
    // R4 R9: pointer untouched by the ignored transaction
    do_read(DEV, 1'b0, 8'h00, 1, 1'b1, "R4 R9 pointer kept");
    // R4: read to another address sees a released line
    do_read(7'h29, 1'b0, 8'h00, 2, 1'b0, "R4 mismatch read");
    // R8: longer sequential current read
    do_read(DEV, 1'b0, 8'h00, 4, 1'b1, "R8 sequential current");
    // R6: burst in the middle, then read it back by index
    wq = '{8'h01, 8'h02, 8'h03, 8'h04};
    do_write(DEV, 8'h40, 1'b1, "R6 mid burst");
    do_read(DEV, 1'b1, 8'h40, 4, 1'b1, "R6 R7 readback");
    chk(sda_oe == 1'b0, "R8 line released after stop", sda_oe, 0);
    repeat (300) @(negedge clk);
    finish_run();
  end
endmodule